// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block holds the digital half of a dual-slope integrating converter. It steps through three phases, each a fixed number of clocks: zeroing, integrating the unknown input, and ramping back with the reference. During each phase it drives exactly one analog switch enable. While the reference ramp runs, it counts clocks in decimal. When the comparator reports that the integrator has crossed zero, the count becomes the reading. The reading is latched together with the input sign and two range flags.

Every measurement cycle has the same length. The clocks that the reference ramp does not use are added to the next zeroing phase. A run enable chooses between free-running conversion and holding the last result. Display scanning, the integrator and the comparator belong to other blocks.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and immediately after it, the zeroing switch is on, busy is low, the result is zero, and the sign and both range flags are low.
- R2: Exactly one of the three switch enables is high in every clock. The first zeroing phase after reset lasts AZ_LEN clocks.
- R3: The integrate phase lasts INT_LEN clocks. Busy rises with the integrate phase and falls when the ramp phase ends, so busy is high for INT_LEN plus the number of ramp clocks.
- R4: The ramp phase ends in the first clock in which zero_cross is sampled high. The reading is the number of whole ramp clocks before that clock. It is output in BCD with digit i in bits [4i+3:4i]. A crossing in the first ramp clock reads 0.
- R5: If no crossing is seen within DEINT_MAX ramp clocks, over_range is set, the digits read zero and under_range is clear. A crossing in the last allowed clock still counts as over-range.
- R6: under_range is set when a valid reading is below 1000, which means digits 3 and 4 are zero. It is clear for readings of 1000 and above.
- R7: While run_en stays high, the time from one integrate start to the next is always AZ_LEN+INT_LEN+DEINT_MAX clocks, whatever the reading.
- R8: result_neg takes the value of polarity_in sampled in the last integrate clock. Changes to polarity_in at any other time have no effect on it.
- R9: The result outputs change only in the clock in which busy falls. A zero_cross pulse outside the ramp phase is ignored.
- R10: If run_en is low when the cycle completes, the block stays in zeroing with busy low and keeps the result. Raising run_en starts integration on the next clock.
- R11: The most significant digit of the result is never above 1. The largest valid reading is DEINT_MAX-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | High: keep converting; low: hold after current cycle |
| zero_cross | input | 1 | Comparator reports integrator crossing zero |
| polarity_in | input | 1 | Comparator sign during integration (1 = negative) |
| az_sw | output | 1 | Zeroing switch enable |
| int_sw | output | 1 | Input integrate switch enable |
| deint_sw | output | 1 | Reference ramp switch enable |
| busy | output | 1 | Integrate or ramp phase in progress |
| result_bcd | output | 20 | Latched reading, five BCD digits |
| result_neg | output | 1 | Latched sign of the reading |
| over_range | output | 1 | Last ramp timed out |
| under_range | output | 1 | Last valid reading below 1000 |

## Verification
The assertions assume that reset is held for at least one clock before any check matters. They make no assumption about how long zero_cross stays high, because only its first sampled high in the ramp phase ends that phase. The stimulus drives zero_cross as a single-clock pulse at a chosen ramp clock, or leaves it low to force a timeout. It changes polarity_in only at integrate start and ramp start, and it also pulses zero_cross during zeroing to show that the pulse is ignored. The phase lengths are scaled down by parameters so that many conversions, including the hold case, fit into the run.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;
endpackage

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter #(
    parameter int NDIG = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            inc,
    output logic [NDIG*4-1:0] count
);
    localparam int W = NDIG * 4;

    logic [W-1:0]  cnt_d, cnt_q;
    logic [NDIG:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic at_nine;
        assign at_nine      = (cnt_q[g*4 +: 4] == 4'd9);
        assign carry[g+1]   = carry[g] & at_nine;
        assign cnt_d[g*4 +: 4] = clr      ? 4'd0 :
                                 carry[g] ? (at_nine ? 4'd0 : cnt_q[g*4 +: 4] + 4'd1) :
                                            cnt_q[g*4 +: 4];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // every digit stays a legal decimal value
    for (genvar g = 0; g < NDIG; g++) begin : g_chk
        assert_digit_legal_R4: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g*4 +: 4] <= 4'd9);
    end
endmodule

// File: rtl/dsadc_phase_ctl.sv
module dsadc_phase_ctl
    import dsadc_pkg::*;
#(
    parameter int AZ_LEN    = 10001,
    parameter int INT_LEN   = 10000,
    parameter int DEINT_MAX = 20001
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run_en,
    input  logic   zero_cross,
    output phase_e phase,
    output logic   int_last,
    output logic   deint_end,
    output logic   deint_ovr
);
    localparam int CYCLE = AZ_LEN + INT_LEN + DEINT_MAX;
    localparam int CW    = $clog2(CYCLE + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE - 1);
    localparam logic [CW-1:0] INT_END  = CW'(INT_LEN - 1);
    localparam logic [CW-1:0] DE_END   = CW'(INT_LEN + DEINT_MAX - 1);
    localparam logic [CW-1:0] AZ_START = CW'(INT_LEN + DEINT_MAX);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cyc;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        int_last  = 1'b0;
        deint_end = 1'b0;
        deint_ovr = 1'b0;
        unique case (s_q.ph)
            PH_AZ: begin
                if (s_q.cyc == CYC_LAST) begin
                    if (run_en) begin
                        s_d.cyc = '0;
                        s_d.ph  = PH_INT;
                    end
                end else begin
                    s_d.cyc = s_q.cyc + 1'b1;
                end
            end
            PH_INT: begin
                s_d.cyc = s_q.cyc + 1'b1;
                if (s_q.cyc == INT_END) begin
                    s_d.ph   = PH_DEINT;
                    int_last = 1'b1;
                end
            end
            PH_DEINT: begin
                s_d.cyc = s_q.cyc + 1'b1;
                if (s_q.cyc == DE_END) begin
                    deint_end = 1'b1;
                    deint_ovr = 1'b1;
                    s_d.ph    = PH_AZ;
                end else if (zero_cross) begin
                    deint_end = 1'b1;
                    s_d.ph    = PH_AZ;
                end
            end
            default: begin
                s_d.ph  = PH_AZ;
                s_d.cyc = AZ_START;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{ph: PH_AZ, cyc: AZ_START};
        else     s_q <= s_d;
    end

    assign phase = s_q.ph;

    assert_int_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_INT) |=> (s_q.ph == PH_INT || s_q.ph == PH_DEINT));

    assert_run_start_R10: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_AZ && s_q.cyc == CYC_LAST && run_en) |=> (s_q.ph == PH_INT));

    assert_hold_stays_R10: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_AZ && s_q.cyc == CYC_LAST && !run_en) |=> (s_q.ph == PH_AZ));

    assert_deint_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_DEINT) |-> (s_q.cyc <= DE_END));
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
    parameter int NDIG      = 5,
    parameter int UNDER_POS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pol_in,
    input  logic              pol_take,
    input  logic              load,
    input  logic              ovr,
    input  logic [NDIG*4-1:0] count,
    output logic [NDIG*4-1:0] result_bcd,
    output logic              result_neg,
    output logic              over_range,
    output logic              under_range
);
    localparam int W = NDIG * 4;

    typedef struct packed {
        logic         pol;
        logic [W-1:0] bcd;
        logic         neg;
        logic         ovr;
        logic         und;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pol_take) r_d.pol = pol_in;
        if (load) begin
            r_d.neg = r_q.pol;
            r_d.ovr = ovr;
            r_d.bcd = ovr ? '0 : count;
            r_d.und = !ovr && (count[W-1:UNDER_POS*4] == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign result_bcd  = r_q.bcd;
    assign result_neg  = r_q.neg;
    assign over_range  = r_q.ovr;
    assign under_range = r_q.und;

    assert_under_digits_R6: assert property (@(posedge clk) disable iff (rst)
        r_q.und |-> (r_q.bcd[W-1:UNDER_POS*4] == '0));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(r_q.und && r_q.ovr));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsadc_pkg::*;
#(
    parameter int AZ_LEN    = 10001,
    parameter int INT_LEN   = 10000,
    parameter int DEINT_MAX = 20001,
    parameter int NDIG      = 5,
    parameter int UNDER_POS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              zero_cross,
    input  logic              polarity_in,
    output logic              az_sw,
    output logic              int_sw,
    output logic              deint_sw,
    output logic              busy,
    output logic [NDIG*4-1:0] result_bcd,
    output logic              result_neg,
    output logic              over_range,
    output logic              under_range
);
    localparam int W = NDIG * 4;

    phase_e       phase;
    logic         int_last;
    logic         deint_end;
    logic         deint_ovr;
    logic [W-1:0] count;

    dsadc_phase_ctl #(
        .AZ_LEN    (AZ_LEN),
        .INT_LEN   (INT_LEN),
        .DEINT_MAX (DEINT_MAX)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .zero_cross (zero_cross),
        .phase      (phase),
        .int_last   (int_last),
        .deint_end  (deint_end),
        .deint_ovr  (deint_ovr)
    );

    dsadc_bcd_counter #(
        .NDIG (NDIG)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (int_last),
        .inc   (phase == PH_DEINT),
        .count (count)
    );

    dsadc_result_reg #(
        .NDIG      (NDIG),
        .UNDER_POS (UNDER_POS)
    ) u_res (
        .clk         (clk),
        .rst         (rst),
        .pol_in      (polarity_in),
        .pol_take    (int_last),
        .load        (deint_end),
        .ovr         (deint_ovr),
        .count       (count),
        .result_bcd  (result_bcd),
        .result_neg  (result_neg),
        .over_range  (over_range),
        .under_range (under_range)
    );

    assign az_sw    = (phase == PH_AZ);
    assign int_sw   = (phase == PH_INT);
    assign deint_sw = (phase == PH_DEINT);
    assign busy     = !az_sw;

    assert_one_switch_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot({az_sw, int_sw, deint_sw}));

    assert_busy_starts_int_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> int_sw);

    assert_result_moves_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable({result_bcd, result_neg, over_range, under_range}) |-> $fell(busy));

    assert_over_zero_R5: assert property (@(posedge clk) disable iff (rst)
        over_range |-> (result_bcd == '0));

    assert_msd_small_R11: assert property (@(posedge clk) disable iff (rst)
        result_bcd[W-1:W-4] <= 4'd1);
endmodule

// File: tb/dual_slope_seq_bench.sv
module dual_slope_seq_bench;
    localparam int AZ  = 1001;
    localparam int IL  = 1000;
    localparam int DM  = 2001;
    localparam int ND  = 5;
    localparam int CYC = AZ + IL + DM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b1;
    logic zero_cross = 1'b0;
    logic polarity_in = 1'b0;
    logic az_sw, int_sw, deint_sw, busy;
    logic [ND*4-1:0] result_bcd;
    logic result_neg, over_range, under_range;

    always #2 clk = ~clk;

    dual_slope_seq #(
        .AZ_LEN(AZ), .INT_LEN(IL), .DEINT_MAX(DM), .NDIG(ND), .UNDER_POS(3)
    ) u_dual_slope_seq (
        .clk(clk), .rst(rst), .run_en(run_en), .zero_cross(zero_cross),
        .polarity_in(polarity_in), .az_sw(az_sw), .int_sw(int_sw),
        .deint_sw(deint_sw), .busy(busy), .result_bcd(result_bcd),
        .result_neg(result_neg), .over_range(over_range), .under_range(under_range)
    );

    typedef struct {
        logic [19:0] bcd;
        logic        neg;
        logic        ovr;
        logic        und;
        int          blen;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   hold_seen = 0;
    bit   finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [19:0] to_bcd(int v);
        logic [19:0] r;
        int t;
        t = v;
        for (int i = 0; i < 5; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // driver: n < 0 means the comparator never crosses
    task automatic convert(int n, bit neg, bit drop_run);
        exp_t e;
        int used;
        e.ovr  = (n < 0) || (n >= DM - 1);
        used   = e.ovr ? DM : n + 1;
        e.bcd  = e.ovr ? 20'h0 : to_bcd(n);
        e.und  = !e.ovr && (n < 1000);
        e.neg  = neg;
        e.blen = IL + used;
        q.push_back(e);
        polarity_in = !neg;
        do @(negedge clk); while (!int_sw);
        polarity_in = neg;
        if (drop_run) run_en = 1'b0;
        do @(negedge clk); while (!deint_sw);
        polarity_in = !neg;
        if (n >= 0) begin
            repeat (n) @(negedge clk);
            zero_cross = 1'b1;
            @(negedge clk);
            zero_cross = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        int nidx;
        int last_rise;
        int blen;
        bit pb;
        exp_t e;
        nidx = 0; last_rise = -1; blen = 0; pb = 1'b0;
        wait (!rst);
        forever begin
            @(negedge clk);
            nidx++;
            if (busy && !pb) begin
                if (last_rise < 0)
                    chk(nidx == AZ, "R2", "first zeroing length", nidx, AZ);
                else if (hold_seen)
                    hold_seen = 0;
                else
                    chk(nidx - last_rise == CYC, "R7", "cycle period", nidx - last_rise, CYC);
                last_rise = nidx;
                blen = 0;
            end
            if (busy) blen++;
            if (!busy && pb) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4", "result with nothing expected", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(result_bcd == e.bcd, "R4", "reading", int'(result_bcd), int'(e.bcd));
                    chk(result_neg == e.neg, "R8", "sign", int'(result_neg), int'(e.neg));
                    chk(over_range == e.ovr, "R5", "over_range", int'(over_range), int'(e.ovr));
                    chk(under_range == e.und, "R6", "under_range", int'(under_range), int'(e.und));
                    chk(blen == e.blen, "R3", "busy length", blen, e.blen);
                    chk(result_bcd[19:16] <= 4'd1, "R11", "top digit", int'(result_bcd[19:16]), 1);
                end
            end
            pb = busy;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R3 watchdog expired: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int bad;
        logic [19:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(az_sw && !busy, "R1", "reset phase", int'({az_sw, busy}), 2);
        chk(result_bcd == 20'h0 && !result_neg && !over_range && !under_range,
            "R1", "reset result", int'(result_bcd), 0);
        rst = 1'b0;

        convert(0, 1'b0, 1'b0);        // R4 zero reading
        convert(1, 1'b1, 1'b0);
        convert(999, 1'b0, 1'b0);      // R6 just under
        // R9: zero_cross during zeroing is ignored
        held = result_bcd;
        repeat (5) @(negedge clk);
        zero_cross = 1'b1;
        repeat (3) @(negedge clk);
        zero_cross = 1'b0;
        @(negedge clk);
        chk(result_bcd == held && !busy, "R9", "stray crossing", int'(result_bcd), int'(held));
        convert(1000, 1'b1, 1'b0);     // R6 just at threshold
        convert(1234, 1'b0, 1'b0);
        convert(1999, 1'b1, 1'b0);     // R11 largest valid
        convert(-1, 1'b0, 1'b0);       // R5 timeout
        convert(2000, 1'b1, 1'b0);     // R5 crossing on last clock
        // R10: hold
        convert(1500, 1'b0, 1'b1);
        bad = 0;
        repeat (2 * CYC) begin
            @(negedge clk);
            if (busy || !az_sw || result_bcd != to_bcd(1500)) bad++;
        end
        chk(bad == 0, "R10", "held clocks not idle", bad, 0);
        hold_seen = 1;
        run_en = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R10", "start after raise", int'(busy), 1);
        convert(321, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4", "pending results", q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule